// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupts

This block controls 64 general-purpose pins split into two banks of 32. Software reaches it through a 16-bit register port. Each 32-bit control word sits at two adjacent halfword addresses. Every pin has a direction bit and an output data bit. Input pins are sampled through a synchroniser before they can be read or used to raise an interrupt. The block also drives 16 pull-enable and 16 pull-direction control bits, which go to pad logic outside it.

The lower 32 pins can each raise an interrupt. Each of these pins has its own settings:
- edge or level detection;
- active polarity;
- a hold mode, in which the status bit latches until software clears it;
- a through mode, in which the status bit tracks the live condition every cycle.

A status bit gated by its enable bit feeds a single registered interrupt request line.

The register port has no back-pressure. A write is accepted on every clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state. There is no stream interface, so all pins are plain control and status signals.

Top module: `pin_io_ctrl`

## Requirements
- R1: Halfword address `a` selects 32-bit word `a>>1`, and `a[0]` selects the half: 0 reaches bits 15:0 and 1 reaches bits 31:16. The word map is:

  | Word | Contents |
  |------|----------|
  | 0 | direction, pins 0-31 |
  | 1 | direction, pins 32-63 |
  | 2 | data, pins 0-31 |
  | 3 | data, pins 32-63 |
  | 4 | interrupt status |
  | 5 | interrupt enable |
  | 6 | trigger type |
  | 7 | polarity |
  | 8 | hold select |
  | 9 | pull control: pull enable in the low half, pull direction in the high half |

  Pin n of a bank is bit n mod 32 of that bank's word.
- R2: A direction bit of 1 makes the pin an output: `pin_oe` is 1 and `pin_out` carries the written data bit. A direction bit of 0 makes the pin an input.
- R3: Reading a data word returns the written data bit for output pins. For input pins it returns `pin_in` after two synchronising flops: a value applied before clock edge k is readable after edge k+1.
- R4: With trigger type 1 (edge), a pin raises its condition for one cycle. With polarity 1 this happens on a 0-to-1 change of the synchronised input; with polarity 0 it happens on a 1-to-0 change.
- R5: With trigger type 0 (level), the condition is true while the synchronised input equals the polarity bit: 1 means active high, 0 means active low.
- R6: With hold 1, a condition sets the status bit and the bit stays set. Writing 1 to a status bit clears it and writing 0 has no effect. If a condition and a clear fall in the same cycle, the condition wins and the bit stays set.
- R7: With hold 0, the status bit equals the condition from the previous cycle, and status writes have no effect.
- R8: `irq` is 1 one cycle after any bit of (status AND enable) is 1, and 0 one cycle after none is.
- R9: A pin whose direction is output raises no interrupt condition. Only pins 0-31 have interrupt logic.
- R10: `pull_en` and `pull_up` drive the two halves of word 9. When a pull is enabled, `pull_up` 1 selects pull-up and 0 selects pull-down.
- R11: Reset makes all pins inputs and sets output data, enables, trigger, polarity, hold, pull and status to 0, with `irq` at 0. After reset, pins left at the default (level, active low, through) with low inputs show status 1.
- R12: Halfword addresses 20 to 31 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Halfword address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 64 | Pin input levels (asynchronous) |
| pin_out | output | 64 | Pin output data |
| pin_oe | output | 64 | Pin output enable (1 = output) |
| pull_en | output | 16 | Pull resistor enable |
| pull_up | output | 16 | Pull direction (1 = up) |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
Two functions can fall in the same cycle.

The first is a write-1 clear of a held status bit that lands while that pin's condition is still active. The bench provokes it by holding a level-high pin asserted while it writes the clear. The bit must read back as still set, and it must clear only after the input is released and a second clear is written.

The second is the registered request line and a status change that happen together. A reference model written in the bench predicts every output and the read data on every clock, under both directed and random traffic, so a one-cycle slip in the request line is flagged.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;
  localparam int ADDR_W = 5;

  // Word index is the halfword address without its lowest bit.
  typedef enum logic [3:0] {
    W_DIR0 = 4'd0,
    W_DIR1 = 4'd1,
    W_DAT0 = 4'd2,
    W_DAT1 = 4'd3,
    W_STAT = 4'd4,
    W_EN   = 4'd5,
    W_TYPE = 4'd6,
    W_POL  = 4'd7,
    W_HOLD = 4'd8,
    W_PULL = 4'd9
  } word_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        chain_q[k] <= chain_q[k-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_slice.sv
module irq_slice (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic is_out,
  input  logic edge_mode,
  input  logic act_high,
  input  logic hold,
  input  logic clr,
  output logic stat
);
  logic prev_q;
  logic lvl_hit;
  logic edge_hit;
  logic cond;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign lvl_hit  = act_high ? level : ~level;
  assign edge_hit = act_high ? (level & ~prev_q) : (~level & prev_q);
  assign cond     = ~is_out & (edge_mode ? edge_hit : lvl_hit);

  always_ff @(posedge clk) begin
    if (rst)       stat <= 1'b0;
    else if (hold) stat <= (stat & ~clr) | cond;
    else           stat <= cond;
  end

  // R6
  held_set_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && cond) |=> stat);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && clr && !cond) |=> !stat);

  // R7
  through_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold) |=> (stat == $past(cond)));
endmodule

// File: rtl/pin_io_ctrl.sv
module pin_io_ctrl
  import pin_io_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [HALF_W-1:0]     reg_wdata,
  output logic [HALF_W-1:0]     reg_rdata,
  input  logic [4*HALF_W-1:0]   pin_in,
  output logic [4*HALF_W-1:0]   pin_out,
  output logic [4*HALF_W-1:0]   pin_oe,
  output logic [HALF_W-1:0]     pull_en,
  output logic [HALF_W-1:0]     pull_up,
  output logic                  irq
);
  localparam int WORD_W   = 2 * HALF_W;
  localparam int PINS     = 2 * WORD_W;
  localparam int IRQ_PINS = WORD_W;

  logic [3:0] word_idx;
  logic       half_hi;
  assign word_idx = reg_addr[ADDR_W-1:1];
  assign half_hi  = reg_addr[0];

  function automatic logic [WORD_W-1:0] put_half(
    input logic [WORD_W-1:0] old,
    input logic              hi,
    input logic [HALF_W-1:0] d
  );
    return hi ? {d, old[HALF_W-1:0]} : {old[WORD_W-1:HALF_W], d};
  endfunction

  logic [1:0][WORD_W-1:0] dir_q;
  logic [1:0][WORD_W-1:0] dat_q;
  logic [WORD_W-1:0]      en_q;
  logic [WORD_W-1:0]      typ_q;
  logic [WORD_W-1:0]      pol_q;
  logic [WORD_W-1:0]      hold_q;
  logic [HALF_W-1:0]      pen_q;
  logic [HALF_W-1:0]      pdir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      dat_q  <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      hold_q <= '0;
      pen_q  <= '0;
      pdir_q <= '0;
    end else if (reg_wr) begin
      case (word_idx)
        W_DIR0, W_DIR1: dir_q[word_idx[0]] <= put_half(dir_q[word_idx[0]], half_hi, reg_wdata);
        W_DAT0, W_DAT1: dat_q[word_idx[0]] <= put_half(dat_q[word_idx[0]], half_hi, reg_wdata);
        W_EN:   en_q   <= put_half(en_q, half_hi, reg_wdata);
        W_TYPE: typ_q  <= put_half(typ_q, half_hi, reg_wdata);
        W_POL:  pol_q  <= put_half(pol_q, half_hi, reg_wdata);
        W_HOLD: hold_q <= put_half(hold_q, half_hi, reg_wdata);
        W_PULL: begin
          if (half_hi) pdir_q <= reg_wdata;
          else         pen_q  <= reg_wdata;
        end
        default: ;
      endcase
    end
  end

  // Pin side
  logic [PINS-1:0] sync_q;
  logic [PINS-1:0] rd_view;

  assign pin_oe  = {dir_q[1], dir_q[0]};
  assign pin_out = {dat_q[1], dat_q[0]};
  assign pull_en = pen_q;
  assign pull_up = pdir_q;

  pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_q)
  );

  assign rd_view = (pin_out & pin_oe) | (sync_q & ~pin_oe);

  // Interrupt side
  logic [IRQ_PINS-1:0] clr_vec;
  logic [IRQ_PINS-1:0] stat;

  always_comb begin
    clr_vec = '0;
    if (reg_wr && word_idx == W_STAT) clr_vec = put_half('0, half_hi, reg_wdata);
  end

  for (genvar i = 0; i < IRQ_PINS; i++) begin : g_irq
    irq_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .level     (sync_q[i]),
      .is_out    (pin_oe[i]),
      .edge_mode (typ_q[i]),
      .act_high  (pol_q[i]),
      .hold      (hold_q[i]),
      .clr       (clr_vec[i]),
      .stat      (stat[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & en_q);
  end

  // Read mux
  logic [WORD_W-1:0] word_sel;

  always_comb begin
    case (word_idx)
      W_DIR0:  word_sel = dir_q[0];
      W_DIR1:  word_sel = dir_q[1];
      W_DAT0:  word_sel = rd_view[WORD_W-1:0];
      W_DAT1:  word_sel = rd_view[PINS-1:WORD_W];
      W_STAT:  word_sel = stat;
      W_EN:    word_sel = en_q;
      W_TYPE:  word_sel = typ_q;
      W_POL:   word_sel = pol_q;
      W_HOLD:  word_sel = hold_q;
      W_PULL:  word_sel = {pdir_q, pen_q};
      default: word_sel = '0;
    endcase
    reg_rdata = half_hi ? word_sel[WORD_W-1:HALF_W] : word_sel[HALF_W-1:0];
  end

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & en_q)) |=> irq);

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & en_q)) |=> !irq);

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (word_idx > 4'd9) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_pin_io_ctrl.sv
`timescale 1ns/1ps
module sim_pin_io_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic [15:0] pull_en, pull_up;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pin_io_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .pull_up(pull_up), .irq(irq)
  );

  // Behavioural reference model
  logic [63:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;
  logic [31:0] m_prev = '0, m_stat = '0, m_en = '0, m_typ = '0, m_pol = '0, m_hold = '0;
  logic [15:0] m_pen = '0, m_pdir = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk) begin
    logic [31:0] nstat;
    logic [31:0] clrw;
    logic lv, c;
    int w;
    if (rst) begin
      m_dir = '0; m_out = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
      m_en = '0; m_typ = '0; m_pol = '0; m_hold = '0; m_pen = '0; m_pdir = '0;
      m_irq = 1'b0;
    end else begin
      clrw = '0;
      if (reg_wr && reg_addr == 5'd8) clrw[15:0]  = reg_wdata;
      if (reg_wr && reg_addr == 5'd9) clrw[31:16] = reg_wdata;
      for (int i = 0; i < 32; i++) begin
        lv = m_s2[i];
        if (m_dir[i])      c = 1'b0;
        else if (m_typ[i]) c = m_pol[i] ? (lv && !m_prev[i]) : (!lv && m_prev[i]);
        else               c = m_pol[i] ? lv : !lv;
        nstat[i] = m_hold[i] ? ((m_stat[i] && !clrw[i]) || c) : c;
      end
      m_irq  = |(m_stat & m_en);
      m_stat = nstat;
      m_prev = m_s2[31:0];
      m_s2   = m_s1;
      m_s1   = pin_in;
      if (reg_wr) begin
        w = int'(reg_addr);
        if (w < 4)        m_dir[16*w +: 16]      = reg_wdata;
        else if (w < 8)   m_out[16*(w-4) +: 16]  = reg_wdata;
        else if (w == 10 || w == 11) m_en[16*(w-10) +: 16]   = reg_wdata;
        else if (w == 12 || w == 13) m_typ[16*(w-12) +: 16]  = reg_wdata;
        else if (w == 14 || w == 15) m_pol[16*(w-14) +: 16]  = reg_wdata;
        else if (w == 16 || w == 17) m_hold[16*(w-16) +: 16] = reg_wdata;
        else if (w == 18) m_pen  = reg_wdata;
        else if (w == 19) m_pdir = reg_wdata;
      end
    end
  end

  function automatic logic [15:0] model_read(input logic [4:0] a);
    logic [63:0] view;
    int w;
    view = (m_out & m_dir) | (m_s2 & ~m_dir);
    w = int'(a);
    if (w < 4)       return m_dir[16*w +: 16];
    else if (w < 8)  return view[16*(w-4) +: 16];
    else if (w < 10) return m_stat[16*(w-8) +: 16];
    else if (w < 12) return m_en[16*(w-10) +: 16];
    else if (w < 14) return m_typ[16*(w-12) +: 16];
    else if (w < 16) return m_pol[16*(w-14) +: 16];
    else if (w < 18) return m_hold[16*(w-16) +: 16];
    else if (w == 18) return m_pen;
    else if (w == 19) return m_pdir;
    return 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    chk("R3 read data", {48'h0, reg_rdata}, {48'h0, model_read(reg_addr)});
    chk("R8 irq", {63'h0, irq}, {63'h0, m_irq});
    chk("R2 pin_oe", pin_oe, m_dir);
    chk("R2 pin_out", pin_out, m_out);
    chk("R10 pulls", {32'h0, pull_up, pull_en}, {32'h0, m_pdir, m_pen});
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1.5;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R11: values while reset is asserted
    rd(5'd0, v);  chk("R11 dir reset", {48'h0, v}, 64'h0);
    rd(5'd8, v);  chk("R11 stat reset", {48'h0, v}, 64'h0);
    rd(5'd10, v); chk("R11 enable reset", {48'h0, v}, 64'h0);
    chk("R11 irq reset", {63'h0, irq}, 64'h0);
    rst = 1'b0;
    idle(2);
    rd(5'd8, v); chk("R11 default level-low status", {48'h0, v}, 64'hFFFF);

    // R2 direction and output data
    wr(5'd0, 16'h00F0);
    wr(5'd4, 16'h00A0);
    idle(1);
    chk("R2 oe low", {48'h0, pin_oe[15:0]}, 64'h00F0);
    chk("R2 out low", {48'h0, pin_out[15:0]}, 64'h00A0);
    // R1 upper half of bank 1
    wr(5'd3, 16'hFFFF);
    wr(5'd7, 16'h1234);
    idle(1);
    chk("R1 oe top", {48'h0, pin_oe[63:48]}, 64'hFFFF);
    chk("R1 out top", {48'h0, pin_out[63:48]}, 64'h1234);
    rd(5'd7, v); chk("R1 readback top", {48'h0, v}, 64'h1234);
    rd(5'd6, v); chk("R1 bank1 low inputs", {48'h0, v}, 64'h0);

    // R3 synchroniser latency
    pin_in[3:0] = 4'h5;
    rd(5'd4, v); chk("R3 not yet visible", {48'h0, v}, 64'h00A0);
    idle(2);
    rd(5'd4, v); chk("R3 visible after sync", {48'h0, v}, 64'h00A5);

    // R4 rising edge, held, pin 20
    wr(5'd13, 16'h0010);
    wr(5'd15, 16'h0010);
    wr(5'd17, 16'h0010);
    wr(5'd11, 16'h0010);
    idle(2);
    rd(5'd9, v); chk("R4 no edge yet", {48'h0, v & 16'h0010}, 64'h0);
    pin_in[20] = 1'b1;
    idle(5);
    rd(5'd9, v); chk("R4 rising edge", {48'h0, v & 16'h0010}, 64'h0010);
    chk("R8 irq on", {63'h0, irq}, 64'h1);
    pin_in[20] = 1'b0;
    idle(5);
    rd(5'd9, v); chk("R6 held after release", {48'h0, v & 16'h0010}, 64'h0010);
    wr(5'd9, 16'h0000);
    rd(5'd9, v); chk("R6 write 0 ignored", {48'h0, v & 16'h0010}, 64'h0010);
    wr(5'd9, 16'h0010);
    idle(2);
    rd(5'd9, v); chk("R6 write 1 clears", {48'h0, v & 16'h0010}, 64'h0);
    chk("R8 irq off", {63'h0, irq}, 64'h0);

    // R4 falling edge, pin 21
    pin_in[21] = 1'b1;
    idle(4);
    wr(5'd13, 16'h0030);
    wr(5'd17, 16'h0030);
    wr(5'd11, 16'h0030);
    wr(5'd9, 16'h0030);
    idle(2);
    rd(5'd9, v); chk("R4 falling armed", {48'h0, v & 16'h0020}, 64'h0);
    pin_in[21] = 1'b0;
    idle(5);
    rd(5'd9, v); chk("R4 falling edge", {48'h0, v & 16'h0020}, 64'h0020);
    wr(5'd9, 16'h0020);
    idle(2);

    // R5 and R7 level through, pin 8
    rd(5'd8, v); chk("R5 active low", {48'h0, v & 16'h0100}, 64'h0100);
    pin_in[8] = 1'b1;
    idle(4);
    rd(5'd8, v); chk("R7 follows release", {48'h0, v & 16'h0100}, 64'h0);
    wr(5'd14, 16'h0100);
    idle(2);
    rd(5'd8, v); chk("R5 active high", {48'h0, v & 16'h0100}, 64'h0100);
    wr(5'd8, 16'h0100);
    rd(5'd8, v); chk("R7 clear has no effect", {48'h0, v & 16'h0100}, 64'h0100);

    // R9 output pin raises nothing, pin 9
    wr(5'd0, 16'h02F0);
    wr(5'd14, 16'h0300);
    pin_in[9] = 1'b1;
    idle(4);
    rd(5'd8, v); chk("R9 output pin silent", {48'h0, v & 16'h0200}, 64'h0);
    chk("R8 gated by enable", {63'h0, irq}, 64'h0);
    wr(5'd10, 16'h0100);
    idle(2);
    chk("R8 enabled raises irq", {63'h0, irq}, 64'h1);
    wr(5'd10, 16'h0000);
    idle(2);
    chk("R8 disabled drops irq", {63'h0, irq}, 64'h0);

    // R6 condition beats clear in the same cycle, pin 22
    pin_in[22] = 1'b1;
    wr(5'd15, 16'h0050);
    wr(5'd17, 16'h0070);
    idle(3);
    rd(5'd9, v); chk("R6 level held set", {48'h0, v & 16'h0040}, 64'h0040);
    wr(5'd9, 16'h0040);
    rd(5'd9, v); chk("R6 set wins over clear", {48'h0, v & 16'h0040}, 64'h0040);
    pin_in[22] = 1'b0;
    idle(4);
    rd(5'd9, v); chk("R6 still held", {48'h0, v & 16'h0040}, 64'h0040);
    wr(5'd9, 16'h0040);
    rd(5'd9, v); chk("R6 cleared", {48'h0, v & 16'h0040}, 64'h0);

    // R10 pulls
    wr(5'd18, 16'h003C);
    wr(5'd19, 16'h000C);
    idle(1);
    chk("R10 pull enable", {48'h0, pull_en}, 64'h003C);
    chk("R10 pull up", {48'h0, pull_up}, 64'h000C);

    // R12 unmapped space
    wr(5'd25, 16'hFFFF);
    rd(5'd25, v); chk("R12 unmapped read", {48'h0, v}, 64'h0);
    rd(5'd20, v); chk("R12 unmapped read 20", {48'h0, v}, 64'h0);
    rd(5'd0, v);  chk("R12 write changed nothing", {48'h0, v}, 64'h02F0);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pin_in = {$urandom, $urandom};
      reg_wr = ($urandom % 3) == 0;
      reg_addr = 5'($urandom % 24);
      reg_wdata = 16'($urandom);
    end
    @(negedge clk);
    reg_wr = 1'b0;
    idle(4);
    summary();
    $finish;
  end
endmodule